// File: doc/BRIEF.md
# Inhibitable Serial Pattern-Detecting Neuron

This block models a firing brain cell as a one-bit serial pattern detector. Each clock period it samples a single data bit. When the bits 1, 0, 1 have arrived on three consecutive cycles, it raises a registered spike output for exactly one clock period. Two control inputs can suppress firing. An inhibit input prevents the cell from firing while it is high. A load-enable input is normally held high, and pulling it low keeps the spike register from capturing a firing.

All storage changes on the falling clock edge. The pattern history is a small state machine with three named states. `HIST_IDLE` means no useful prefix has been seen. `HIST_ONE` means the last bit was a 1. `HIST_ONE_ZERO` means the last two bits were 1 then 0. The named transitions are as follows:
- `HIST_IDLE` moves to `HIST_ONE` on a 1 and stays put on a 0.
- `HIST_ONE` stays in `HIST_ONE` on a 1 and moves to `HIST_ONE_ZERO` on a 0.
- `HIST_ONE_ZERO` moves to `HIST_IDLE` on a 0.
- On a 1 in `HIST_ONE_ZERO`, the completing bit, there are two cases. If inhibit is low, the cell fires and the history returns to `HIST_IDLE`. If inhibit is high, the history moves to `HIST_ONE`.

The firing decision is Mealy-style. It is formed from the stored history together with the present data and inhibit bits. The spike register never feeds back into that decision.

Top module: `seq_neuron`

## Requirements
- R1: A synchronous, active-high reset sampled at a falling edge clears the spike output to 0 and the history to `HIST_IDLE`. After reset, the input 0, 1 alone does not fire.
- R2: When the bits 1, 0, 1 arrive on consecutive falling edges with inhibit 0 and load enable 1, the spike output goes to 1 right after the falling edge that samples the final 1.
- R3: The spike output stays high for exactly one clock period and is 0 after the next falling edge, unless a new firing occurs at that edge.
- R4: When inhibit is 1 on the completing edge, the spike stays 0 and the history moves to `HIST_ONE` without being cleared. A following 0, 1 with inhibit 0 then fires.
- R5: When load enable is 0 on a completing edge with inhibit 0, the spike register loads 0. The history is still cleared to `HIST_IDLE`, so a following 0, 1 does not fire.
- R6: Firing clears the history, so matches never overlap. The input 1, 0, 1, 0, 1 fires once only, at the third bit.
- R7: In `HIST_ONE`, a 1 keeps the state, so 1, 1, 0, 1 fires. In `HIST_ONE_ZERO`, a 0 returns to `HIST_IDLE`, so 1, 0, 0, 1 does not fire.
- R8: Reset takes priority over every other input. A completing 1 sampled together with reset leaves the spike at 0.
- R9: The spike output has no effect on later firing decisions. Each firing depends only on the data, inhibit and load-enable history since the last clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All registers update on its falling edge. |
| rst | input | 1 | Synchronous active-high reset. |
| data_bit | input | 1 | Serial data bit, sampled once per period. |
| inhibit | input | 1 | When high, blocks firing. |
| load_en | input | 1 | Normally high. When low, stops the spike register from capturing a firing. |
| spike | output | 1 | Registered firing output, high for one period per firing. |

## Verification
Two functions can fall in the same falling edge: a pattern completion and a suppression. The suppression is either inhibit, reset, or load enable held low. They act differently on the history. Inhibit leaves the history advancing, while load enable low still clears it. Both cases are provoked by sweeping every five-bit data pattern against every five-bit inhibit mask and every five-bit load-enable mask. A long random stream with all three inputs toggling follows the sweeps. Each cycle's spike value is compared with an arithmetic model in the bench. Directed streams then follow each suppressed completion with 0, 1, and judge from the spike output alone whether the hidden history was cleared.

// File: rtl/neuron_pkg.sv
package neuron_pkg;
    localparam int HIST_W = 2;

    typedef enum logic [HIST_W-1:0] {
        HIST_IDLE     = 2'd0,
        HIST_ONE      = 2'd1,
        HIST_ONE_ZERO = 2'd2
    } hist_t;
endpackage

// File: rtl/neuron_hist.sv
module neuron_hist
    import neuron_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_in,
    input  logic  clear_req,
    output hist_t state,
    output logic  complete
);
    hist_t state_nxt;

    assign complete = (state == HIST_ONE_ZERO) && bit_in;

    always_comb begin
        state_nxt = state;
        if (clear_req) begin
            state_nxt = HIST_IDLE;
        end else begin
            unique case (state)
                HIST_IDLE:     state_nxt = bit_in ? HIST_ONE : HIST_IDLE;
                HIST_ONE:      state_nxt = bit_in ? HIST_ONE : HIST_ONE_ZERO;
                HIST_ONE_ZERO: state_nxt = bit_in ? HIST_ONE : HIST_IDLE;
                default:       state_nxt = HIST_IDLE;
            endcase
        end
    end

    always_ff @(negedge clk) begin
        if (rst) state <= HIST_IDLE;
        else     state <= state_nxt;
    end

    // R6
    clear_to_idle_chk: assert property (@(negedge clk) disable iff (rst)
        clear_req |=> state == HIST_IDLE);

    // R7
    one_hold_chk: assert property (@(negedge clk) disable iff (rst)
        (state == HIST_ONE && bit_in && !clear_req) |=> state == HIST_ONE);

    // R7
    one_zero_drop_chk: assert property (@(negedge clk) disable iff (rst)
        (state == HIST_ONE_ZERO && !bit_in) |=> state == HIST_IDLE);
endmodule

// File: rtl/neuron_fire_reg.sv
module neuron_fire_reg (
    input  logic clk,
    input  logic rst,
    input  logic fire_req,
    input  logic load_en,
    output logic spike
);
    logic spike_nxt;

    always_comb begin
        spike_nxt = fire_req && load_en;
    end

    always_ff @(negedge clk) begin
        if (rst) spike <= 1'b0;
        else     spike <= spike_nxt;
    end

    // R5
    load_block_chk: assert property (@(negedge clk) disable iff (rst)
        !load_en |=> !spike);

    // R2
    fire_capture_chk: assert property (@(negedge clk) disable iff (rst)
        (fire_req && load_en) |=> spike);
endmodule

// File: rtl/seq_neuron.sv
module seq_neuron
    import neuron_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic data_bit,
    input  logic inhibit,
    input  logic load_en,
    output logic spike
);
    hist_t hist_state;
    logic  complete;
    logic  fire_req;

    assign fire_req = complete && !inhibit;

    neuron_hist u_hist (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (data_bit),
        .clear_req(fire_req),
        .state    (hist_state),
        .complete (complete)
    );

    neuron_fire_reg u_fire (
        .clk     (clk),
        .rst     (rst),
        .fire_req(fire_req),
        .load_en (load_en),
        .spike   (spike)
    );

    // R1 R8
    reset_clear_chk: assert property (@(negedge clk)
        rst |=> (!spike && hist_state == HIST_IDLE));

    // R4
    inhibit_block_chk: assert property (@(negedge clk) disable iff (rst)
        inhibit |=> !spike);

    // R4
    inhibit_keep_chk: assert property (@(negedge clk) disable iff (rst)
        (complete && inhibit) |=> hist_state == HIST_ONE);

    // R3
    one_period_chk: assert property (@(negedge clk) disable iff (rst)
        spike |=> !spike);
endmodule

// File: tb/tb_seq_neuron.sv
`timescale 1ns/1ps
module tb_seq_neuron;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic data_bit = 1'b0;
    logic inhibit = 1'b0;
    logic load_en = 1'b1;
    logic spike;

    int n_run  = 0;
    int n_fail = 0;
    int m_hist = 0;
    logic m_spike = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seq_neuron dut (
        .clk     (clk),
        .rst     (rst),
        .data_bit(data_bit),
        .inhibit (inhibit),
        .load_en (load_en),
        .spike   (spike)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: spike=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one period: drive after rising edge, check just after falling edge
    task automatic step(input logic d, input logic i, input logic l, input logic r,
                        input string tag);
        logic hit;
        @(posedge clk);
        data_bit = d; inhibit = i; load_en = l; rst = r;
        hit = (m_hist == 2) && d && !i;
        if (r) begin
            m_hist = 0; m_spike = 1'b0;
        end else begin
            m_spike = hit && l;
            if (hit)                m_hist = 0;
            else if (d)             m_hist = 1;
            else if (m_hist == 1)   m_hist = 2;
            else                    m_hist = 0;
        end
        @(negedge clk);
        #1;
        check(spike, m_spike, tag);
    endtask

    task automatic do_reset();
        step(1'b0, 1'b0, 1'b1, 1'b1, "R1");
    endtask

    // run a 3-bit pattern (msb first) with given ctrl, used by directed cases
    task automatic seq3(input logic [2:0] d, input logic [2:0] i, input logic [2:0] l,
                        input string tag);
        for (int k = 2; k >= 0; k--) step(d[k], i[k], l[k], 1'b0, tag);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then 0,1 alone must not fire
        do_reset();
        do_reset();
        check(spike, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R1");
        check(spike, 1'b0, "R1");

        // R2 R3: basic fire and one-period pulse
        do_reset();
        seq3(3'b101, 3'b000, 3'b111, "R2");
        check(spike, 1'b1, "R2");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R3");
        check(spike, 1'b0, "R3");

        // R6: 10101 fires once only
        do_reset();
        seq3(3'b101, 3'b000, 3'b111, "R6");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R6");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R6");
        check(spike, 1'b0, "R6");

        // R7: 1101 fires, 1001 does not
        do_reset();
        step(1'b1, 1'b0, 1'b1, 1'b0, "R7");
        seq3(3'b101, 3'b000, 3'b111, "R7");
        check(spike, 1'b1, "R7");
        do_reset();
        step(1'b1, 1'b0, 1'b1, 1'b0, "R7");
        seq3(3'b001, 3'b000, 3'b111, "R7");
        check(spike, 1'b0, "R7");

        // R4: inhibited completion keeps history; 0,1 then fires
        do_reset();
        seq3(3'b101, 3'b001, 3'b111, "R4");
        check(spike, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R4");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R4");
        check(spike, 1'b1, "R4");

        // R5: load low clears history; 0,1 then does not fire
        do_reset();
        seq3(3'b101, 3'b000, 3'b110, "R5");
        check(spike, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R5");
        check(spike, 1'b0, "R5");

        // R8: reset on the completing edge wins
        do_reset();
        step(1'b1, 1'b0, 1'b1, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R8");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R8");
        check(spike, 1'b0, "R8");

        // R9: back-to-back patterns fire regardless of previous spike
        do_reset();
        seq3(3'b101, 3'b000, 3'b111, "R9");
        seq3(3'b101, 3'b000, 3'b111, "R9");
        check(spike, 1'b1, "R9");

        // R2 R4: sweep data patterns against inhibit masks
        for (int p = 0; p < 32; p++) begin
            for (int q = 0; q < 32; q++) begin
                do_reset();
                for (int k = 4; k >= 0; k--)
                    step(p[k], q[k], 1'b1, 1'b0, "R2_R4_sweep");
            end
        end

        // R5: sweep data patterns against load-enable masks
        for (int p = 0; p < 32; p++) begin
            for (int q = 0; q < 32; q++) begin
                do_reset();
                for (int k = 4; k >= 0; k--)
                    step(p[k], 1'b0, q[k], 1'b0, "R5_sweep");
            end
        end

        // R6 R7 R9: long random stream with all controls
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            int unsigned v;
            v = $urandom;
            step(v[0], (v[3:1] == 3'd0), (v[6:4] != 3'd0), (v[15:8] == 8'd0),
                 "R6_R7_R9_random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule